// File: doc/BRIEF.md
# ADC Serial Control and Readout Port

This block is the digital serial port of an eight-channel, 12-bit sampling converter, placed on the device side. A host writes a five-bit control word through a serial input framed by an active-low transmit strobe. The block returns a sixteen-bit result through a serial output framed by an active-low receive strobe. The upper three control bits choose the input channel. The block also gates the external convert-start edge against an acquisition timer. That timer starts each time a control word is accepted.

The port works in one of two clocking modes. In slave mode the host supplies the serial clock and the receive strobe, and the block samples both with its system clock. In master mode the block divides its system clock to make the serial clock. It opens a sixteen-period receive frame by itself after each conversion result arrives. The converter core delivers results on a parallel bus with a one-cycle done strobe. The block asks the core to begin a conversion with a one-cycle start pulse.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, the channel select and flag outputs are 0, `sdo` is 0, `rfs_out_n` is 1, `conv_start` is 0 and `acq_busy` is 0.
- R2: Once `tfs_n` falls, `sdi` is sampled on each of the next five falling serial-clock edges. The first bit is the channel MSB, then channel bits 1 and 0, then flag bit 1, then flag bit 0. The new word takes effect at the fifth edge.
- R3: While `tfs_n` stays low, serial-clock edges after the fifth do not change the control word.
- R4: If `tfs_n` returns high before the fifth falling edge, the control word keeps its old value.
- R5: A receive frame carries 16 bits, MSB first: a 0, the three channel bits (MSB first) as they were when the frame opened, then the 12 data bits (MSB first). Bit k is valid at the (k+1)th falling serial-clock edge after the receive strobe falls.
- R6: While the receive strobe is high, `sdo` is 0.
- R7: The result register loads only on `conv_done`. A `conv_done` during an open frame does not change that frame, and the new value appears in the next frame.
- R8: With parameter `TWOS_COMP` = 0, the data field equals `conv_data`. With `TWOS_COMP` = 1, the MSB of the data field is inverted, which gives two's complement.
- R9: In master mode, `sclk_out` has a period of `SCLK_DIV` system clocks. After each `conv_done`, `rfs_out_n` goes low on a rising `sclk_out` edge and stays low for exactly 16 periods, which covers 16 falling edges. In slave mode, `sclk_out` and `rfs_out_n` are held at 1.
- R10: A rising `convst` while `acq_busy` is low gives exactly one single-cycle `conv_start` pulse within three cycles.
- R11: A rising `convst` while `acq_busy` is high gives no pulse until `acq_busy` falls, and then exactly one.
- R12: Each accepted control word sets `acq_busy` high for exactly `ACQ_CYCLES` system clocks.
- R13: When `tfs_n` and the receive strobe are driven together, the same frame writes a control word and reads a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1: serial clock and receive strobe are inputs; 0: generated internally |
| sclk_in | input | 1 | Serial clock in slave mode |
| rfs_in_n | input | 1 | Receive strobe in slave mode, active low |
| tfs_n | input | 1 | Transmit strobe for the control word, active low |
| sdi | input | 1 | Serial control data |
| convst | input | 1 | Convert-start request, rising-edge active |
| conv_done | input | 1 | One-cycle strobe that marks a valid result |
| conv_data | input | 12 | Conversion result from the core, straight binary |
| sclk_out | output | 1 | Generated serial clock (held high in slave mode) |
| rfs_out_n | output | 1 | Generated receive strobe (held high in slave mode) |
| sdo | output | 1 | Serial result data |
| chan_sel | output | 3 | Selected input channel |
| ctrl_flags | output | 2 | Low two control-word bits |
| conv_start | output | 1 | One-cycle pulse that starts hold and conversion |
| acq_busy | output | 1 | High while the acquisition timer runs |

## Verification
The assertions check on every cycle that a start pulse lasts one cycle, and that it never follows a cycle in which the acquisition timer was running. They also check that the channel changes only together with a timer restart, and that in master mode the receive strobe moves only on a rising serial-clock edge. The bench scenarios cover the rest. These include the bit order and content of frames, and what happens when the transmit strobe rises early or stays low past the fifth bit. They also include a result that arrives in the middle of a frame, the two data codings, combined write-and-read frames with random words and data, and the exact length of the timer and of the master frame.

// File: rtl/adc_serial_port.sv
`timescale 1ns/1ps
module adc_serial_port #(
  parameter int DATA_W     = 12,
  parameter int ADDR_W     = 3,
  parameter int CTRL_W     = 5,
  parameter int SCLK_DIV   = 8,
  parameter int ACQ_CYCLES = 40,
  parameter bit TWOS_COMP  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              sclk_in,
  input  logic              rfs_in_n,
  input  logic              tfs_n,
  input  logic              sdi,
  input  logic              convst,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              sclk_out,
  output logic              rfs_out_n,
  output logic              sdo,
  output logic [ADDR_W-1:0] chan_sel,
  output logic [CTRL_W-ADDR_W-1:0] ctrl_flags,
  output logic              conv_start,
  output logic              acq_busy
);
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int HALF    = SCLK_DIV / 2;
  localparam int HC_W    = $clog2(HALF + 1);
  localparam int FC_W    = $clog2(FRAME_W + 1);
  localparam int CC_W    = $clog2(CTRL_W + 1);
  localparam int AC_W    = $clog2(ACQ_CYCLES + 1);

  logic [1:0] s_sclk, s_rfs, s_tfs, s_sdi, s_cv;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_sclk <= 2'b11; s_rfs <= 2'b11; s_tfs <= 2'b11;
      s_sdi  <= 2'b00; s_cv  <= 2'b00;
    end else begin
      s_sclk <= {s_sclk[0], sclk_in};
      s_rfs  <= {s_rfs[0], rfs_in_n};
      s_tfs  <= {s_tfs[0], tfs_n};
      s_sdi  <= {s_sdi[0], sdi};
      s_cv   <= {s_cv[0], convst};
    end

  logic [HC_W-1:0] hcnt;
  logic [FC_W-1:0] mcnt;
  logic m_sclk, m_rfs, m_pend;
  wire  m_tick = (hcnt == HC_W'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt <= '0; m_sclk <= 1'b1; m_rfs <= 1'b1; m_pend <= 1'b0; mcnt <= '0;
    end else begin
      hcnt <= m_tick ? '0 : hcnt + 1'b1;
      if (m_tick) m_sclk <= ~m_sclk;
      if (slave_mode) begin
        m_rfs <= 1'b1; m_pend <= 1'b0; mcnt <= '0;
      end else begin
        if (conv_done) m_pend <= 1'b1;
        if (m_tick && !m_sclk) begin
          if (!m_rfs && mcnt == FC_W'(FRAME_W)) m_rfs <= 1'b1;
          else if (m_rfs && m_pend) begin
            m_rfs <= 1'b0; mcnt <= '0; m_pend <= conv_done;
          end
        end
        if (m_tick && m_sclk && !m_rfs) mcnt <= mcnt + 1'b1;
      end
    end

  assign sclk_out  = slave_mode | m_sclk;
  assign rfs_out_n = slave_mode | m_rfs;

  wire sclk_i = slave_mode ? s_sclk[1] : m_sclk;
  wire rfs_i  = slave_mode ? s_rfs[1]  : m_rfs;
  wire tfs_i  = s_tfs[1];

  logic sclk_q, rfs_q, tfs_q, cv_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= 1'b1; rfs_q <= 1'b1; tfs_q <= 1'b1; cv_q <= 1'b0;
    end else begin
      sclk_q <= sclk_i; rfs_q <= rfs_i; tfs_q <= tfs_i; cv_q <= s_cv[1];
    end

  wire sc_fall  = sclk_q & ~sclk_i;
  wire sc_rise  = ~sclk_q & sclk_i;
  wire rfs_fall = rfs_q & ~rfs_i;
  wire tfs_fall = tfs_q & ~tfs_i;
  wire cv_rise  = ~cv_q & s_cv[1];

  logic [DATA_W-1:0] coded, result;
  if (TWOS_COMP) begin : g_twos
    assign coded = {~conv_data[DATA_W-1], conv_data[DATA_W-2:0]};
  end else begin : g_straight
    assign coded = conv_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) result <= '0;
    else if (conv_done) result <= coded;

  logic [CTRL_W-1:0] ctrl, csr;
  logic [CC_W-1:0]   ccnt;
  wire commit = !tfs_i && !tfs_fall && sc_fall && ccnt == CC_W'(CTRL_W - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; csr <= '0; ccnt <= CC_W'(CTRL_W);
    end else begin
      if (tfs_fall) ccnt <= '0;
      else if (!tfs_i && sc_fall && ccnt != CC_W'(CTRL_W)) begin
        csr  <= {csr[CTRL_W-2:0], s_sdi[1]};
        ccnt <= ccnt + 1'b1;
      end
      if (commit) ctrl <= {csr[CTRL_W-2:0], s_sdi[1]};
    end

  assign chan_sel   = ctrl[CTRL_W-1 -: ADDR_W];
  assign ctrl_flags = ctrl[CTRL_W-ADDR_W-1:0];

  logic [FRAME_W-1:0] osr;
  logic [FC_W-1:0]    ocnt;
  logic               o_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      osr <= '0; ocnt <= '0; o_seen <= 1'b0;
    end else if (rfs_fall) begin
      osr <= {1'b0, chan_sel, result}; ocnt <= '0; o_seen <= 1'b0;
    end else if (!rfs_i) begin
      if (sc_fall) o_seen <= 1'b1;
      if (sc_rise && o_seen && ocnt != FC_W'(FRAME_W - 1)) begin
        osr  <= osr << 1;
        ocnt <= ocnt + 1'b1;
      end
    end

  assign sdo = ~rfs_i & osr[FRAME_W-1];

  logic [AC_W-1:0] acq;
  logic cv_pend, start_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acq <= '0; cv_pend <= 1'b0; start_q <= 1'b0;
    end else begin
      if (commit) acq <= AC_W'(ACQ_CYCLES);
      else if (acq != '0) acq <= acq - 1'b1;
      start_q <= (acq == '0) && (cv_rise || cv_pend);
      if (acq == '0) cv_pend <= 1'b0;
      else if (cv_rise) cv_pend <= 1'b1;
    end

  assign conv_start = start_q;
  assign acq_busy   = (acq != '0);
endmodule

// File: rtl/adc_serial_port_chk.sv
`timescale 1ns/1ps
module adc_serial_port_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode,
  input logic              sclk_out,
  input logic              rfs_out_n,
  input logic              conv_start,
  input logic              acq_busy,
  input logic [ADDR_W-1:0] chan_sel
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R10
  AST_START_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(acq_busy)); // R11
  AST_CHAN_WITH_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_sel) |-> acq_busy); // R12
  AST_FRAME_OPENS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $past(!slave_mode) && $fell(rfs_out_n)) |-> $rose(sclk_out)); // R9
  AST_FRAME_CLOSES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $past(!slave_mode) && $rose(rfs_out_n)) |-> $rose(sclk_out)); // R9
endmodule

bind adc_serial_port adc_serial_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .sclk_out(sclk_out),
  .rfs_out_n(rfs_out_n), .conv_start(conv_start), .acq_busy(acq_busy),
  .chan_sel(chan_sel)
);

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int SCLK_DIV   = 8;
  localparam int ACQ_CYCLES = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slave_mode = 1'b1, sclk_in = 1'b1, rfs_in_n = 1'b1, tfs_n = 1'b1, sdi = 1'b0;
  logic convst = 1'b0, conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic sclk_out, rfs_out_n, sdo, conv_start, acq_busy;
  logic [2:0] chan_sel;
  logic [1:0] ctrl_flags;
  logic sclk_out2, rfs_out_n2, sdo2, conv_start2, acq_busy2;
  logic [2:0] chan_sel2;
  logic [1:0] ctrl_flags2;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port #(.SCLK_DIV(SCLK_DIV), .ACQ_CYCLES(ACQ_CYCLES)) i_adc_serial_port (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .sclk_in(sclk_in),
    .rfs_in_n(rfs_in_n), .tfs_n(tfs_n), .sdi(sdi), .convst(convst),
    .conv_done(conv_done), .conv_data(conv_data), .sclk_out(sclk_out),
    .rfs_out_n(rfs_out_n), .sdo(sdo), .chan_sel(chan_sel), .ctrl_flags(ctrl_flags),
    .conv_start(conv_start), .acq_busy(acq_busy));

  adc_serial_port #(.SCLK_DIV(SCLK_DIV), .ACQ_CYCLES(ACQ_CYCLES), .TWOS_COMP(1'b1)) i_adc_serial_port_tc (
    .clk(clk), .rst_n(rst_n), .slave_mode(1'b1), .sclk_in(sclk_in),
    .rfs_in_n(rfs_in_n), .tfs_n(tfs_n), .sdi(sdi), .convst(convst),
    .conv_done(conv_done), .conv_data(conv_data), .sclk_out(sclk_out2),
    .rfs_out_n(rfs_out_n2), .sdo(sdo2), .chan_sel(chan_sel2), .ctrl_flags(ctrl_flags2),
    .conv_start(conv_start2), .acq_busy(acq_busy2));

  int total = 0, bad = 0, cyc = 0;
  int starts = 0, last_start = 0, t_rise = 0, t_fall = 0, busy_len = 0;
  logic busy_prev = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (conv_start) begin starts <= starts + 1; last_start <= cyc; end
    if (acq_busy && !busy_prev) t_rise <= cyc;
    if (!acq_busy && busy_prev) begin busy_len <= cyc - t_rise; t_fall <= cyc; end
    busy_prev <= acq_busy;
  end

  function automatic logic [15:0] frame_exp(input logic [2:0] ch, input logic [11:0] d, input bit tc);
    return {1'b0, ch, tc ? ~d[11] : d[11], d[10:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_conv(input logic [11:0] d);
    conv_data = d; conv_done = 1'b1; tick(1); conv_done = 1'b0; tick(1);
  endtask

  task automatic frame(input logic [4:0] word, input int nf, input bit wr, input bit rd,
                       input int tfs_stop, input bit mid, input logic [11:0] mid_d,
                       output logic [15:0] cap, output logic [15:0] cap2);
    cap = '0; cap2 = '0;
    tfs_n = !wr; rfs_in_n = !rd;
    tick(H);
    for (int i = 0; i < nf; i++) begin
      sdi = (i < 5) ? word[4-i] : 1'($urandom_range(0, 1));
      tick(H);
      if (i < 16) begin cap[15-i] = sdo; cap2[15-i] = sdo2; end
      sclk_in = 1'b0;
      tick(H);
      if (mid && i == 8) begin
        conv_data = mid_d; conv_done = 1'b1; tick(1); conv_done = 1'b0;
      end
      sclk_in = 1'b1;
      if (i + 1 == tfs_stop) tfs_n = 1'b1;
    end
    tick(H);
    tfs_n = 1'b1; rfs_in_n = 1'b1;
    tick(H);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && acq_busy; k++) tick(1);
    tick(2);
  endtask

  initial begin
    logic [15:0] c1, c2;
    logic [4:0] w, cur;
    logic [11:0] d, data_now;
    int prior, t0, nfall;
    logic prev;
    void'($urandom(32'd2024));

    tick(5); rst_n = 1'b1; tick(3);
    check(chan_sel == 3'd0 && ctrl_flags == 2'd0, "R1 ctrl", {chan_sel, ctrl_flags}, 0);
    check(sdo == 1'b0 && rfs_out_n == 1'b1, "R1 sdo/rfs_out_n", {sdo, rfs_out_n}, 1);
    check(conv_start == 1'b0 && acq_busy == 1'b0, "R1 start/busy", {conv_start, acq_busy}, 0);

    prev = 1'b1;
    for (int k = 0; k < 20; k++) begin prev &= sclk_out & rfs_out_n; tick(1); end
    check(prev, "R9 slave quiet outputs", prev, 1);

    do_conv(12'hA5C); data_now = 12'hA5C;

    frame(5'b10110, 5, 1, 0, 99, 0, 0, c1, c2);
    check(chan_sel == 3'b101 && ctrl_flags == 2'b10, "R2 write", {chan_sel, ctrl_flags}, 5'b10110);
    check(c1 == 16'h0, "R6 sdo idle with rfs high", c1, 0);

    frame(5'b01011, 12, 1, 0, 99, 0, 0, c1, c2);
    check({chan_sel, ctrl_flags} == 5'b01011, "R3 extra bits ignored", {chan_sel, ctrl_flags}, 5'b01011);

    frame(5'b11100, 8, 1, 0, 3, 0, 0, c1, c2);
    check({chan_sel, ctrl_flags} == 5'b01011, "R4 short frame ignored", {chan_sel, ctrl_flags}, 5'b01011);
    cur = 5'b01011;

    frame(5'b0, 16, 0, 1, 99, 0, 0, c1, c2);
    check(c1 == frame_exp(3'b010, data_now, 0), "R5 frame order", c1, frame_exp(3'b010, data_now, 0));
    check(c2 == frame_exp(3'b010, data_now, 1), "R8 twos complement coding", c2, frame_exp(3'b010, data_now, 1));
    check(c1[11:0] == data_now, "R8 straight coding", c1[11:0], data_now);

    do_conv(12'h123); data_now = 12'h123;
    frame(5'b0, 16, 0, 1, 99, 1, 12'hFFF, c1, c2);
    check(c1 == frame_exp(3'b010, 12'h123, 0), "R7 frame not corrupted", c1, frame_exp(3'b010, 12'h123, 0));
    data_now = 12'hFFF;
    frame(5'b0, 16, 0, 1, 99, 0, 0, c1, c2);
    check(c1 == frame_exp(3'b010, 12'hFFF, 0), "R7 new result next frame", c1, frame_exp(3'b010, 12'hFFF, 0));

    for (int n = 0; n < 20; n++) begin
      w = 5'($urandom_range(0, 31));
      d = 12'($urandom_range(0, 4095));
      if (n == 0) d = 12'h000;
      if (n == 1) d = 12'h800;
      if (n == 2) d = 12'h7FF;
      do_conv(d);
      frame(w, 16, 1, 1, 99, 0, 0, c1, c2);
      check(c1 == frame_exp(cur[4:2], d, 0), "R13 tied read", c1, frame_exp(cur[4:2], d, 0));
      check(c2 == frame_exp(cur[4:2], d, 1), "R8 tied read coded", c2, frame_exp(cur[4:2], d, 1));
      check({chan_sel, ctrl_flags} == w, "R13 tied write", {chan_sel, ctrl_flags}, w);
      cur = w;
    end

    wait_idle();
    check(busy_len == ACQ_CYCLES, "R12 timer length", busy_len, ACQ_CYCLES);

    prior = starts;
    convst = 1'b1; tick(5);
    check(starts == prior + 1, "R10 immediate start", starts, prior + 1);
    convst = 1'b0; tick(4);

    frame(5'b11001, 5, 1, 0, 99, 0, 0, c1, c2);
    check(acq_busy == 1'b1, "R12 busy after write", acq_busy, 1);
    prior = starts;
    convst = 1'b1; tick(6);
    check(starts == prior, "R11 start deferred", starts, prior);
    wait_idle(); tick(3);
    check(starts == prior + 1, "R11 one deferred start", starts, prior + 1);
    check(last_start >= t_fall, "R11 start after timer", last_start, t_fall);
    convst = 1'b0; tick(4);

    slave_mode = 1'b0; tick(20);
    do_conv(12'h5A3);
    for (int k = 0; k < 200 && rfs_out_n; k++) tick(1);
    t0 = cyc; nfall = 0; c1 = '0; prev = sclk_out;
    for (int k = 0; k < 400 && !rfs_out_n; k++) begin
      tick(1);
      if (prev && !sclk_out) begin c1 = {c1[14:0], sdo}; nfall++; end
      prev = sclk_out;
    end
    check(nfall == 16, "R9 master falls", nfall, 16);
    check(cyc - t0 == 16 * SCLK_DIV, "R9 master frame length", cyc - t0, 16 * SCLK_DIV);
    check(c1 == frame_exp(3'b110, 12'h5A3, 0), "R5 master frame data", c1, frame_exp(3'b110, 12'h5A3, 0));

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule